// File: doc/BRIEF.md
# Wish Branch Mode Controller

This front-end control unit decides, for every decoded branch that carries wish-branch marking, whether fetch follows the predicted direction like an ordinary conditional branch (confident mode) or walks straight through the if-converted code in order (unconfident mode). When the direction predictor's confidence bit is set, the controller also enables predicate-value prediction for the guarding predicate register, so that consumers need not wait for the real predicate. When confidence is low, the real predicate value is used and no prediction is made.

At resolution the controller decides whether a misprediction costs a pipeline flush. Jumps and joins handled in unconfident mode never flush, because the predicated blocks already computed the right result. A wish loop that has dropped into unconfident mode stays there until the loop leaves. Its mispredictions fall into three classes. Leaving too soon flushes. Leaving too late is absorbed, because the surplus iterations run with a false predicate. Never having fetched an exit flushes. The pipeline carries the mode flag that was issued for each branch and hands it back at resolution time. Only one jump/join region is tracked at a time.

All outputs are registered. A decode or resolve event presented in one cycle shows on the outputs in the following cycle.

Top module: `wish_mode_ctrl`

## Requirements
- R1: After reset every output is zero. An idle cycle (no decode) gives redir_valid_o = 0.
- R2: A branch with dec_wish_i = 0, or a wish branch with kind code 3, is passed through. The redirect goes to dec_target_i if predicted taken and to dec_next_i otherwise, with mode_low_o = 0 and pvp_en_o = 0. This also applies to a wish jump that is demoted (R6).
- R3: A resolved misprediction with res_low_i = 0 raises flush_o one cycle later.
- R4: A wish jump (kind code 0) with confidence set follows the prediction. It drives mode_low_o = 0 and pvp_en_o = 1, and pvp_preg_o carries the predicate register number.
- R5: A wish jump with confidence clear redirects to dec_next_i whatever the prediction, with mode_low_o = 1 and pvp_en_o = 0.
- R6: While a region opened by a wish jump is still open, a further wish jump is treated as a normal branch. A wish join (kind code 2) seen while no region is open is also treated as a normal branch.
- R7: A wish join closes the open region. If the region was opened in confident mode, the join follows its prediction. If the region was opened in unconfident mode, the join falls through to dec_next_i with mode_low_o = 1.
- R8: A misprediction of a wish jump or join resolved with res_low_i = 1 raises no flush.
- R9: A wish loop (kind code 1) decoded with confidence clear enters unconfident mode. Later decodes of that loop stay unconfident, even when confident, until a loop resolution with actual not-taken or a flush.
- R10: Early exit. An unconfident loop resolved as mispredicted with actual direction taken raises flush_o, and loop_exit_o = 1.
- R11: Late exit. An unconfident loop resolved as mispredicted with actual not-taken, after an unconfident decode predicted the exit, raises no flush. loop_exit_o = 2, and unconfident loop mode ends.
- R12: No exit. The same resolution with no predicted exit decoded yet raises flush_o, and loop_exit_o = 3.
- R13: When a flush and a decode fall in the same cycle, the flush wins. redir_valid_o is 0, the decode changes no region or loop state, and all region and loop state is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dec_valid_i | input | 1 | A branch is decoded this cycle |
| dec_wish_i | input | 1 | 1 = wish branch, 0 = normal branch |
| dec_kind_i | input | 2 | Wish kind: 0 jump, 1 loop, 2 join, 3 treated as normal |
| dec_preg_i | input | PREG_W | Guarding predicate register number |
| dec_taken_i | input | 1 | Predicted direction |
| dec_conf_i | input | 1 | Prediction confidence, 1 = confident |
| dec_target_i | input | ADDR_W | Branch target address |
| dec_next_i | input | ADDR_W | Fall-through address |
| res_valid_i | input | 1 | A branch resolves this cycle |
| res_wish_i | input | 1 | Resolving branch is a wish branch |
| res_kind_i | input | 2 | Wish kind of the resolving branch |
| res_low_i | input | 1 | Mode flag that was issued for this branch |
| res_mispred_i | input | 1 | Prediction was wrong |
| res_taken_i | input | 1 | Actual direction |
| redir_valid_o | output | 1 | Fetch redirect is valid |
| redir_pc_o | output | ADDR_W | Next fetch address |
| mode_low_o | output | 1 | Branch handled in unconfident mode |
| pvp_en_o | output | 1 | Predict the guarding predicate's value |
| pvp_preg_o | output | PREG_W | Predicate register to predict |
| flush_o | output | 1 | Pipeline flush request |
| loop_exit_o | output | 2 | Loop outcome: 0 none, 1 early, 2 late, 3 no exit |

## Verification
A decode and a flushing resolution can land in the same cycle. The concern is that the decode then redirects fetch, or opens a region, that the flush should have cancelled. The bench first presents a wish jump with confidence clear, which would open an unconfident region, together with a mispredicted normal resolution. It checks that the flush appears and that no redirect is issued. It then decodes a taken wish join and expects normal pass-through to dec_target_i with mode_low_o = 0. A surviving region would instead make the join fall through with mode_low_o = 1.

// File: rtl/wbm_pkg.sv
package wbm_pkg;
  typedef enum logic [1:0] {
    WK_JUMP = 2'd0,
    WK_LOOP = 2'd1,
    WK_JOIN = 2'd2,
    WK_RSVD = 2'd3
  } wish_kind_e;

  typedef enum logic [1:0] {
    LX_NONE   = 2'd0,
    LX_EARLY  = 2'd1,
    LX_LATE   = 2'd2,
    LX_NOEXIT = 2'd3
  } loop_exit_e;

  typedef struct packed {
    logic dir;         // 1 = fetch target
    logic low;
    logic pvp;
    logic open_rgn;
    logic close_rgn;
    logic loop_low_set;
    logic exit_seen_set;
  } dec_plan_t;
endpackage

// File: rtl/wbm_decide.sv
module wbm_decide
  import wbm_pkg::*;
(
  input  logic       wish_i,
  input  logic [1:0] kind_i,
  input  logic       taken_i,
  input  logic       conf_i,
  input  logic       rgn_open_i,
  input  logic       rgn_low_i,
  input  logic       loop_low_i,
  output dec_plan_t  plan_o
);
  wish_kind_e kind;
  logic       loop_unconf;

  assign kind        = wish_kind_e'(kind_i);
  assign loop_unconf = loop_low_i | ~conf_i;

  always_comb begin
    plan_o     = '0;
    plan_o.dir = taken_i;
    if (wish_i) begin
      unique case (kind)
        WK_JUMP: begin
          // second jump inside an open region degrades to a normal branch
          if (!rgn_open_i) begin
            plan_o.open_rgn = 1'b1;
            plan_o.low      = ~conf_i;
            plan_o.pvp      = conf_i;
            plan_o.dir      = conf_i & taken_i;
          end
        end
        WK_JOIN: begin
          if (rgn_open_i) begin
            plan_o.close_rgn = 1'b1;
            plan_o.low       = rgn_low_i;
            plan_o.pvp       = ~rgn_low_i;
            plan_o.dir       = ~rgn_low_i & taken_i;
          end
        end
        WK_LOOP: begin
          plan_o.low           = loop_unconf;
          plan_o.pvp           = ~loop_unconf;
          plan_o.loop_low_set  = loop_unconf;
          plan_o.exit_seen_set = loop_unconf & ~taken_i;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/wbm_resolve.sv
module wbm_resolve
  import wbm_pkg::*;
(
  input  logic       valid_i,
  input  logic       wish_i,
  input  logic [1:0] kind_i,
  input  logic       low_i,
  input  logic       mispred_i,
  input  logic       taken_i,
  input  logic       exit_seen_i,
  output logic       flush_o,
  output loop_exit_e exit_o,
  output logic       loop_done_o
);
  wish_kind_e kind;
  logic       handled_low;

  assign kind        = wish_kind_e'(kind_i);
  assign handled_low = low_i & wish_i & (kind != WK_RSVD);

  always_comb begin
    flush_o     = 1'b0;
    exit_o      = LX_NONE;
    loop_done_o = 1'b0;
    if (valid_i) begin
      if (handled_low && kind == WK_LOOP && mispred_i) begin
        if (taken_i) begin
          flush_o = 1'b1;
          exit_o  = LX_EARLY;
        end else if (exit_seen_i) begin
          exit_o  = LX_LATE;    // surplus iterations ran as no-ops
        end else begin
          flush_o = 1'b1;
          exit_o  = LX_NOEXIT;
        end
      end else if (!handled_low && mispred_i) begin
        flush_o = 1'b1;
      end
      loop_done_o = wish_i & (kind == WK_LOOP) & ~taken_i;
    end
  end
endmodule

// File: rtl/wbm_state.sv
module wbm_state
  import wbm_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      flush_i,
  input  logic      dec_valid_i,
  input  dec_plan_t plan_i,
  input  logic      clr_loop_i,
  output logic      rgn_open_o,
  output logic      rgn_low_o,
  output logic      loop_low_o,
  output logic      exit_seen_o
);
  logic rgn_open_q, rgn_low_q, loop_low_q, exit_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rgn_open_q  <= 1'b0;
      rgn_low_q   <= 1'b0;
      loop_low_q  <= 1'b0;
      exit_seen_q <= 1'b0;
    end else if (flush_i) begin
      rgn_open_q  <= 1'b0;
      rgn_low_q   <= 1'b0;
      loop_low_q  <= 1'b0;
      exit_seen_q <= 1'b0;
    end else begin
      if (dec_valid_i && plan_i.open_rgn) begin
        rgn_open_q <= 1'b1;
        rgn_low_q  <= plan_i.low;
      end else if (dec_valid_i && plan_i.close_rgn) begin
        rgn_open_q <= 1'b0;
        rgn_low_q  <= 1'b0;
      end
      // younger decode wins over a same-cycle exit
      loop_low_q  <= (loop_low_q & ~clr_loop_i) | (dec_valid_i & plan_i.loop_low_set);
      exit_seen_q <= (exit_seen_q & ~clr_loop_i) | (dec_valid_i & plan_i.exit_seen_set);
    end
  end

  assign rgn_open_o  = rgn_open_q;
  assign rgn_low_o   = rgn_low_q;
  assign loop_low_o  = loop_low_q;
  assign exit_seen_o = exit_seen_q;

  p_loop_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop_low_q && !flush_i && !clr_loop_i |=> loop_low_q)
    else $error("unconfident loop mode dropped early");

  p_exit_needs_low_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exit_seen_q |-> loop_low_q)
    else $error("exit seen outside unconfident loop");

  p_flush_clears_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !rgn_open_q && !loop_low_q)
    else $error("state survived flush");
endmodule

// File: rtl/wish_mode_ctrl.sv
module wish_mode_ctrl
  import wbm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PREG_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dec_valid_i,
  input  logic              dec_wish_i,
  input  logic [1:0]        dec_kind_i,
  input  logic [PREG_W-1:0] dec_preg_i,
  input  logic              dec_taken_i,
  input  logic              dec_conf_i,
  input  logic [ADDR_W-1:0] dec_target_i,
  input  logic [ADDR_W-1:0] dec_next_i,
  input  logic              res_valid_i,
  input  logic              res_wish_i,
  input  logic [1:0]        res_kind_i,
  input  logic              res_low_i,
  input  logic              res_mispred_i,
  input  logic              res_taken_i,
  output logic              redir_valid_o,
  output logic [ADDR_W-1:0] redir_pc_o,
  output logic              mode_low_o,
  output logic              pvp_en_o,
  output logic [PREG_W-1:0] pvp_preg_o,
  output logic              flush_o,
  output logic [1:0]        loop_exit_o
);
  dec_plan_t  plan;
  logic       rgn_open, rgn_low, loop_low, exit_seen;
  logic       flush, loop_done;
  loop_exit_e exit_kind;

  wbm_decide u_decide (
    .wish_i     (dec_wish_i),
    .kind_i     (dec_kind_i),
    .taken_i    (dec_taken_i),
    .conf_i     (dec_conf_i),
    .rgn_open_i (rgn_open),
    .rgn_low_i  (rgn_low),
    .loop_low_i (loop_low),
    .plan_o     (plan)
  );

  wbm_resolve u_resolve (
    .valid_i     (res_valid_i),
    .wish_i      (res_wish_i),
    .kind_i      (res_kind_i),
    .low_i       (res_low_i),
    .mispred_i   (res_mispred_i),
    .taken_i     (res_taken_i),
    .exit_seen_i (exit_seen),
    .flush_o     (flush),
    .exit_o      (exit_kind),
    .loop_done_o (loop_done)
  );

  wbm_state u_state (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush),
    .dec_valid_i (dec_valid_i),
    .plan_i      (plan),
    .clr_loop_i  (loop_done),
    .rgn_open_o  (rgn_open),
    .rgn_low_o   (rgn_low),
    .loop_low_o  (loop_low),
    .exit_seen_o (exit_seen)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redir_valid_o <= 1'b0;
      redir_pc_o    <= '0;
      mode_low_o    <= 1'b0;
      pvp_en_o      <= 1'b0;
      pvp_preg_o    <= '0;
      flush_o       <= 1'b0;
      loop_exit_o   <= LX_NONE;
    end else begin
      flush_o     <= flush;
      loop_exit_o <= exit_kind;
      if (flush || !dec_valid_i) begin
        redir_valid_o <= 1'b0;
        redir_pc_o    <= '0;
        mode_low_o    <= 1'b0;
        pvp_en_o      <= 1'b0;
        pvp_preg_o    <= '0;
      end else begin
        redir_valid_o <= 1'b1;
        redir_pc_o    <= plan.dir ? dec_target_i : dec_next_i;
        mode_low_o    <= plan.low;
        pvp_en_o      <= plan.pvp;
        pvp_preg_o    <= plan.pvp ? dec_preg_i : '0;
      end
    end
  end

  p_pvp_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pvp_en_o && mode_low_o))
    else $error("predicate prediction in unconfident mode");

  p_plain_flush_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_i && !res_low_i && res_mispred_i |=> flush_o && !redir_valid_o)
    else $error("confident mispredict did not flush");

  p_low_region_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_i && res_low_i && res_wish_i && res_mispred_i &&
    (res_kind_i == 2'd0 || res_kind_i == 2'd2) |=> !flush_o)
    else $error("unconfident jump/join flushed");

  p_late_no_flush_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop_exit_o == 2'd2 |-> !flush_o)
    else $error("late exit flushed");

  p_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_valid_i |=> !redir_valid_o)
    else $error("redirect without decode");
endmodule

// File: tb/wish_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module wish_mode_ctrl_tb_top;
  localparam int ADDR_W = 32;
  localparam int PREG_W = 6;
  localparam logic [31:0] TGT = 32'h0000_1000;
  localparam logic [31:0] NXT = 32'h0000_2000;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic dec_valid_i = 0, dec_wish_i = 0, dec_taken_i = 0, dec_conf_i = 0;
  logic [1:0] dec_kind_i = 0;
  logic [PREG_W-1:0] dec_preg_i = 0;
  logic [ADDR_W-1:0] dec_target_i = TGT, dec_next_i = NXT;
  logic res_valid_i = 0, res_wish_i = 0, res_low_i = 0, res_mispred_i = 0, res_taken_i = 0;
  logic [1:0] res_kind_i = 0;
  logic redir_valid_o, mode_low_o, pvp_en_o, flush_o;
  logic [ADDR_W-1:0] redir_pc_o;
  logic [PREG_W-1:0] pvp_preg_o;
  logic [1:0] loop_exit_o;

  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  wish_mode_ctrl #(.ADDR_W(ADDR_W), .PREG_W(PREG_W)) dut_i (.*);

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // drive at negedge, result sampled at the following negedge
  task automatic step(input logic dv, input logic dw, input logic [1:0] dk, input logic dt, input logic dc,
                      input logic rv, input logic rw, input logic [1:0] rk, input logic rl,
                      input logic rm, input logic rt);
    dec_valid_i = dv; dec_wish_i = dw; dec_kind_i = dk; dec_taken_i = dt; dec_conf_i = dc;
    dec_preg_i = 6'd5;
    res_valid_i = rv; res_wish_i = rw; res_kind_i = rk; res_low_i = rl;
    res_mispred_i = rm; res_taken_i = rt;
    @(posedge clk_i);
    @(negedge clk_i);
    dec_valid_i = 0; res_valid_i = 0;
  endtask

  task automatic dec(input logic w, input logic [1:0] k, input logic t, input logic c);
    step(1, w, k, t, c, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic res(input logic w, input logic [1:0] k, input logic l, input logic m, input logic t);
    step(0, 0, 0, 0, 0, 1, w, k, l, m, t);
  endtask

  task automatic t_reset;
    chk("R1", "redir_valid", redir_valid_o, 0);
    chk("R1", "flush", flush_o, 0);
    chk("R1", "mode_low", mode_low_o, 0);
    chk("R1", "pvp_en", pvp_en_o, 0);
    chk("R1", "loop_exit", loop_exit_o, 0);
  endtask

  task automatic t_normal;
    dec(0, 0, 1, 1);
    chk("R2", "taken pc", redir_pc_o, TGT);
    chk("R2", "valid", redir_valid_o, 1);
    chk("R2", "pvp off", pvp_en_o, 0);
    dec(0, 0, 0, 0);
    chk("R2", "fallthrough pc", redir_pc_o, NXT);
    chk("R2", "mode", mode_low_o, 0);
    dec(1, 3, 1, 0);
    chk("R2", "kind3 pc", redir_pc_o, TGT);
    chk("R2", "kind3 mode", mode_low_o, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R1", "idle valid", redir_valid_o, 0);
    res(0, 0, 0, 1, 1);
    chk("R3", "normal flush", flush_o, 1);
  endtask

  task automatic t_jump_high;
    dec(1, 0, 1, 1);
    chk("R4", "pc", redir_pc_o, TGT);
    chk("R4", "mode", mode_low_o, 0);
    chk("R4", "pvp", pvp_en_o, 1);
    chk("R4", "preg", pvp_preg_o, 5);
    dec(1, 2, 1, 1);
    chk("R7", "high join pc", redir_pc_o, TGT);
    chk("R7", "high join mode", mode_low_o, 0);
    res(1, 0, 0, 1, 0);
    chk("R3", "high jump flush", flush_o, 1);
  endtask

  task automatic t_jump_low;
    dec(1, 0, 1, 0);
    chk("R5", "pc", redir_pc_o, NXT);
    chk("R5", "mode", mode_low_o, 1);
    chk("R5", "pvp", pvp_en_o, 0);
    dec(1, 0, 1, 1);
    chk("R6", "nested jump pc", redir_pc_o, TGT);
    chk("R6", "nested jump pvp", pvp_en_o, 0);
    chk("R6", "nested jump mode", mode_low_o, 0);
    dec(1, 2, 1, 1);
    chk("R7", "low join pc", redir_pc_o, NXT);
    chk("R7", "low join mode", mode_low_o, 1);
    dec(1, 2, 1, 1);
    chk("R6", "orphan join pc", redir_pc_o, TGT);
    chk("R6", "orphan join mode", mode_low_o, 0);
    res(1, 0, 1, 1, 1);
    chk("R8", "low jump no flush", flush_o, 0);
    res(1, 2, 1, 1, 0);
    chk("R8", "low join no flush", flush_o, 0);
  endtask

  task automatic t_loop_early;
    dec(1, 1, 1, 0);
    chk("R9", "enter mode", mode_low_o, 1);
    chk("R9", "enter pc", redir_pc_o, TGT);
    dec(1, 1, 1, 1);
    chk("R9", "sticky mode", mode_low_o, 1);
    chk("R9", "sticky pvp", pvp_en_o, 0);
    res(1, 1, 1, 1, 1);
    chk("R10", "flush", flush_o, 1);
    chk("R10", "exit code", loop_exit_o, 1);
    dec(1, 1, 1, 1);
    chk("R9", "after flush mode", mode_low_o, 0);
    chk("R9", "after flush pvp", pvp_en_o, 1);
  endtask

  task automatic t_loop_late;
    dec(1, 1, 1, 0);
    dec(1, 1, 0, 0);
    chk("R11", "exit fetch pc", redir_pc_o, NXT);
    chk("R11", "exit fetch mode", mode_low_o, 1);
    res(1, 1, 1, 1, 0);
    chk("R11", "no flush", flush_o, 0);
    chk("R11", "exit code", loop_exit_o, 2);
    dec(1, 1, 1, 1);
    chk("R11", "mode cleared", mode_low_o, 0);
  endtask

  task automatic t_loop_noexit;
    dec(1, 1, 1, 0);
    res(1, 1, 1, 1, 0);
    chk("R12", "flush", flush_o, 1);
    chk("R12", "exit code", loop_exit_o, 3);
  endtask

  task automatic t_collide;
    step(1, 1, 0, 1, 0, 1, 0, 0, 0, 1, 1);
    chk("R13", "flush", flush_o, 1);
    chk("R13", "no redirect", redir_valid_o, 0);
    dec(1, 2, 1, 1);
    chk("R13", "join pc", redir_pc_o, TGT);
    chk("R13", "join mode", mode_low_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_normal();
    t_jump_high();
    t_jump_low();
    t_loop_early();
    t_loop_late();
    t_loop_noexit();
    t_collide();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule